// File: doc/BRIEF.md
# Packetised Register Access Decoder

This block turns a byte stream arriving from a host-side FIFO bridge into register transactions for numbered modules inside the chip. Each packet opens with a fixed eight-byte header. The header carries a marker byte of zero and a byte that holds the transfer direction and the target module. After these come a 24-bit start address and a 24-bit transfer length counted in 16-bit words.

In a write packet, the header is followed by the payload words, and each word becomes one write on the module request bus. In a read packet, the block fetches the words one at a time from consecutive addresses. It waits for each response and sends every word back on the output byte stream. A burst of any length up to 2^24-1 words uses the same single header.

Only one module number is served. Payloads for any other number are drained, and reads from any other number return zeros. Both byte streams use valid/ready handshakes, so a full return FIFO stalls the decoder without losing data.

Top module: `pkt_dec_top`

## Requirements
- R1: After reset the decoder accepts input (in_ready=1), presents no output byte (out_valid=0) and issues no request (req_valid=0).
- R2: While waiting for a packet start, any byte other than 0x00 is discarded with no effect. The next 0x00 byte begins a new header.
- R3: Header byte 2 carries the direction in bit 7 (1 = write, 0 = read) and the module number in bits 6:0. Bytes 3 to 5 are the start address and bytes 6 to 8 the word count, both most significant byte first.
- R4: Each write word arrives as two bytes, high byte first. On the cycle after its low byte is accepted, the decoder raises req_valid for one cycle with req_we=1 and the header module, current address and assembled word.
- R5: Successive words of a burst use addresses that increase by one from the start address and wrap from 0xFFFFFF to 0x000000.
- R6: A word count of zero issues no request and produces no output byte. The following byte is treated as the start of a new packet.
- R7: For each read word, the decoder issues one request with req_we=0 and waits for rsp_valid. It then emits the returned word on the output stream, high byte first, and stops accepting input until the packet is complete.
- R8: For a module number other than the served one, write payload bytes are consumed without any request. A read returns 0x00 for every byte, also without any request.
- R9: The decoder never offers an output byte and accepts input in the same cycle. While out_valid is high and out_ready is low, out_valid and out_data hold.
- R10: A pulse on rsp_valid while no read response is awaited is ignored. It adds no output byte and does not change later read data.
- R11: A request never lasts longer than one cycle. req_valid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Incoming packet byte |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Decoder accepts the incoming byte |
| out_data | output | 8 | Returned read byte |
| out_valid | output | 1 | Returned byte present |
| out_ready | input | 1 | Downstream accepts the returned byte |
| req_valid | output | 1 | One-cycle module request strobe |
| req_we | output | 1 | Request is a write |
| req_module | output | 7 | Target module number |
| req_addr | output | 24 | Register address of the request |
| req_wdata | output | 16 | Write word |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | 16 | Read response word |

## Verification
A header collector that loses its byte position shows up immediately: the next request carries a shifted address or module number, or a read packet is handled as a write. If the word tracker drifts, the wrong number of requests or return bytes appears, and that is visible by the end of the packet. A stuck state leaves in_ready low and output silent until the run times out. Misrouted response capture shows up as wrong returned bytes within three cycles of the response strobe.

// File: rtl/pkt_dec_pkg.sv
package pkt_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int MOD_W  = 7;
  localparam logic [BYTE_W-1:0] START_BYTE = 8'h00;

  typedef enum logic [2:0] {
    ST_SYNC,
    ST_HDR,
    ST_WHI,
    ST_WLO,
    ST_RREQ,
    ST_RWAIT,
    ST_RHI,
    ST_RLO
  } dec_state_e;
endpackage

// File: rtl/pkt_dec_hdr.sv
module pkt_dec_hdr
  import pkt_dec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              last,
  output logic              dir_wr,
  output logic [MOD_W-1:0]  module_id,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len
);
  localparam int BODY_BYTES = 1 + ADDR_W / BYTE_W + LEN_W / BYTE_W;
  localparam int BODY_W     = BODY_BYTES * BYTE_W;
  localparam int SH_W       = BODY_W - BYTE_W;
  localparam int CNT_W      = $clog2(BODY_BYTES + 1);

  logic [SH_W-1:0]   sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BODY_W-1:0] full;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sh_d  = {sh_q[SH_W-BYTE_W-1:0], byte_in};
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr || shift_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign full      = {sh_q, byte_in};
  assign last      = (cnt_q == CNT_W'(BODY_BYTES - 1));
  assign dir_wr    = full[BODY_W-1];
  assign module_id = full[BODY_W-2 -: MOD_W];
  assign addr      = full[LEN_W +: ADDR_W];
  assign len       = full[0 +: LEN_W];
endmodule

// File: rtl/pkt_dec_track.sv
module pkt_dec_track #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              rem_last
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    if (load) begin
      addr_d = ld_addr;
      rem_d  = ld_len;
    end else if (step) begin
      addr_d = addr_q + ADDR_W'(1);
      rem_d  = rem_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load || step) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign cur_addr = addr_q;
  assign rem_last = (rem_q == LEN_W'(1));
endmodule

// File: rtl/pkt_dec_top.sv
module pkt_dec_top
  import pkt_dec_pkg::*;
#(
  parameter int               ADDR_W     = 24,
  parameter int               LEN_W      = 24,
  parameter logic [MOD_W-1:0] TARGET_MOD = 7'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              req_valid,
  output logic              req_we,
  output logic [6:0]        req_module,
  output logic [ADDR_W-1:0] req_addr,
  output logic [15:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_data
);
  dec_state_e st_q, st_d;

  logic              in_fire, out_fire;
  logic              hdr_clr, hdr_shift, hdr_last, hdr_wr;
  logic [MOD_W-1:0]  hdr_mod;
  logic [ADDR_W-1:0] hdr_addr;
  logic [LEN_W-1:0]  hdr_len;
  logic              trk_load, trk_step, trk_last;
  logic [ADDR_W-1:0] trk_addr;

  logic              known_q, known_d;
  logic [MOD_W-1:0]  mod_q, mod_d;
  logic [BYTE_W-1:0] whi_q, whi_d;
  logic [WORD_W-1:0] rbuf_q, rbuf_d;
  logic              rq_v_q, rq_v_d, rq_we_q, rq_we_d;
  logic [ADDR_W-1:0] rq_a_q, rq_a_d;
  logic [WORD_W-1:0] rq_w_q, rq_w_d;

  assign in_ready  = (st_q == ST_SYNC) || (st_q == ST_HDR) ||
                     (st_q == ST_WHI)  || (st_q == ST_WLO);
  assign out_valid = (st_q == ST_RHI) || (st_q == ST_RLO);
  assign out_data  = (st_q == ST_RHI) ? rbuf_q[WORD_W-1 -: BYTE_W] : rbuf_q[BYTE_W-1:0];
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  pkt_dec_hdr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (hdr_clr),
    .shift_en (hdr_shift),
    .byte_in  (in_data),
    .last     (hdr_last),
    .dir_wr   (hdr_wr),
    .module_id(hdr_mod),
    .addr     (hdr_addr),
    .len      (hdr_len)
  );

  pkt_dec_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (trk_load),
    .ld_addr (hdr_addr),
    .ld_len  (hdr_len),
    .step    (trk_step),
    .cur_addr(trk_addr),
    .rem_last(trk_last)
  );

  always_comb begin
    st_d      = st_q;
    known_d   = known_q;
    mod_d     = mod_q;
    whi_d     = whi_q;
    rbuf_d    = rbuf_q;
    rq_v_d    = 1'b0;
    rq_we_d   = rq_we_q;
    rq_a_d    = rq_a_q;
    rq_w_d    = rq_w_q;
    hdr_clr   = 1'b0;
    hdr_shift = 1'b0;
    trk_load  = 1'b0;
    trk_step  = 1'b0;
    unique case (st_q)
      ST_SYNC: begin
        if (in_fire && in_data == START_BYTE) begin
          hdr_clr = 1'b1;
          st_d    = ST_HDR;
        end
      end
      ST_HDR: begin
        if (in_fire) begin
          hdr_shift = 1'b1;
          if (hdr_last) begin
            trk_load = 1'b1;
            mod_d    = hdr_mod;
            known_d  = (hdr_mod == TARGET_MOD);
            if (hdr_len == '0)  st_d = ST_SYNC;
            else if (hdr_wr)    st_d = ST_WHI;
            else                st_d = ST_RREQ;
          end
        end
      end
      ST_WHI: begin
        if (in_fire) begin
          whi_d = in_data;
          st_d  = ST_WLO;
        end
      end
      ST_WLO: begin
        if (in_fire) begin
          if (known_q) begin
            rq_v_d  = 1'b1;
            rq_we_d = 1'b1;
            rq_a_d  = trk_addr;
            rq_w_d  = {whi_q, in_data};
          end
          trk_step = 1'b1;
          st_d     = trk_last ? ST_SYNC : ST_WHI;
        end
      end
      ST_RREQ: begin
        if (known_q) begin
          rq_v_d  = 1'b1;
          rq_we_d = 1'b0;
          rq_a_d  = trk_addr;
          st_d    = ST_RWAIT;
        end else begin
          rbuf_d = '0;
          st_d   = ST_RHI;
        end
      end
      ST_RWAIT: begin
        if (rsp_valid) begin
          rbuf_d = rsp_data;
          st_d   = ST_RHI;
        end
      end
      ST_RHI: begin
        if (out_fire) st_d = ST_RLO;
      end
      ST_RLO: begin
        if (out_fire) begin
          trk_step = 1'b1;
          st_d     = trk_last ? ST_SYNC : ST_RREQ;
        end
      end
      default: st_d = ST_SYNC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SYNC;
      known_q <= 1'b0;
      mod_q   <= '0;
      whi_q   <= '0;
      rbuf_q  <= '0;
      rq_v_q  <= 1'b0;
      rq_we_q <= 1'b0;
      rq_a_q  <= '0;
      rq_w_q  <= '0;
    end else begin
      st_q    <= st_d;
      known_q <= known_d;
      mod_q   <= mod_d;
      whi_q   <= whi_d;
      rbuf_q  <= rbuf_d;
      rq_v_q  <= rq_v_d;
      rq_we_q <= rq_we_d;
      rq_a_q  <= rq_a_d;
      rq_w_q  <= rq_w_d;
    end
  end

  assign req_valid  = rq_v_q;
  assign req_we     = rq_we_q;
  assign req_module = mod_q;
  assign req_addr   = rq_a_q;
  assign req_wdata  = rq_w_q;
endmodule

// File: rtl/pkt_dec_chk.sv
module pkt_dec_chk #(
  parameter logic [6:0] TARGET_MOD = 7'h01
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       req_valid,
  input logic       req_we,
  input logic [6:0] req_module
);
  AST_IO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready)); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R11

  AST_REQ_SERVED_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_module == TARGET_MOD)); // R8

  AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> (!in_ready && !out_valid)); // R7
endmodule

bind pkt_dec_top pkt_dec_chk #(.TARGET_MOD(TARGET_MOD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .req_valid (req_valid),
  .req_we    (req_we),
  .req_module(req_module)
);

// File: tb/pkt_dec_top_tb.sv
module pkt_dec_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  in_data;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready;
  logic        req_valid, req_we;
  logic [6:0]  req_module;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_dec_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .req_valid(req_valid), .req_we(req_we), .req_module(req_module),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  function automatic logic [15:0] model(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  // request log
  logic        lg_we   [0:63];
  logic [6:0]  lg_mod  [0:63];
  logic [23:0] lg_addr [0:63];
  logic [15:0] lg_data [0:63];
  int nlog;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) nlog <= 0;
    else if (req_valid && nlog < 64) begin
      lg_we[nlog]   <= req_we;
      lg_mod[nlog]  <= req_module;
      lg_addr[nlog] <= req_addr;
      lg_data[nlog] <= req_wdata;
      nlog <= nlog + 1;
    end
  end

  // module model answering reads two cycles after the request
  logic [1:0]  dly;
  logic [23:0] pend;
  logic        stray;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly <= 2'd0; pend <= '0; rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (req_valid && !req_we) begin
        dly <= 2'd2; pend <= req_addr;
      end else if (dly != 2'd0) dly <= dly - 2'd1;
      if (dly == 2'd1) begin
        rsp_valid <= 1'b1; rsp_data <= model(pend);
      end else if (stray) begin
        rsp_valid <= 1'b1; rsp_data <= 16'hDEAD;
      end
    end
  end

  // output collector and monitors
  logic [7:0] rx [0:255];
  int nrx, overlap, dbl_req;
  logic prev_req;
  logic [7:0] cyc;
  logic stall_en;
  assign out_ready = !stall_en || (cyc[1:0] == 2'b11);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrx <= 0; overlap <= 0; dbl_req <= 0; prev_req <= 1'b0; cyc <= '0;
    end else begin
      cyc <= cyc + 8'd1;
      prev_req <= req_valid;
      if (req_valid && prev_req) dbl_req <= dbl_req + 1;
      if (out_valid && in_ready) overlap <= overlap + 1;
      if (out_valid && out_ready && nrx < 256) begin
        rx[nrx] <= out_data; nrx <= nrx + 1;
      end
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_data = b; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_hdr(input bit wr, input logic [6:0] m,
                          input logic [23:0] a, input logic [23:0] l);
    send_byte(8'h00);
    send_byte({wr, m});
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    send_byte(l[23:16]); send_byte(l[15:8]); send_byte(l[7:0]);
  endtask

  task automatic send_word(input logic [15:0] w);
    send_byte(w[15:8]); send_byte(w[7:0]);
  endtask

  task automatic wait_rx(input int target);
    for (int i = 0; i < 3000 && nrx < target; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "req_valid", 32'(req_valid), 32'd0);
  endtask

  task automatic t_single_write;
    int b = nlog;
    send_hdr(1'b1, 7'h01, 24'h000005, 24'd1);
    send_word(16'h33AA);
    idle(4);
    chk("R4", "write count", 32'(nlog - b), 32'd1);
    chk("R4", "we", 32'(lg_we[b]), 32'd1);
    chk("R3", "module", 32'(lg_mod[b]), 32'h01);
    chk("R3", "addr", 32'(lg_addr[b]), 32'h5);
    chk("R4", "wdata", 32'(lg_data[b]), 32'h33AA);
  endtask

  task automatic t_burst_write;
    int b = nlog;
    send_hdr(1'b1, 7'h01, 24'hFFFFFE, 24'd3);
    send_word(16'h1111); send_word(16'h2222); send_word(16'h3333);
    idle(4);
    chk("R5", "burst count", 32'(nlog - b), 32'd3);
    chk("R5", "addr0", 32'(lg_addr[b]), 32'hFFFFFE);
    chk("R5", "addr1", 32'(lg_addr[b+1]), 32'hFFFFFF);
    chk("R5", "addr2 wrap", 32'(lg_addr[b+2]), 32'h000000);
    chk("R4", "data2", 32'(lg_data[b+2]), 32'h3333);
  endtask

  task automatic t_resync;
    int b = nlog;
    send_byte(8'h7F); send_byte(8'h12);
    idle(2);
    chk("R2", "no request from junk", 32'(nlog - b), 32'd0);
    send_hdr(1'b1, 7'h01, 24'h000040, 24'd1);
    send_word(16'hBEEF);
    idle(4);
    chk("R2", "count after resync", 32'(nlog - b), 32'd1);
    chk("R2", "addr after resync", 32'(lg_addr[b]), 32'h40);
    chk("R2", "data after resync", 32'(lg_data[b]), 32'hBEEF);
  endtask

  task automatic t_zero_len;
    int b = nlog;
    int r = nrx;
    send_hdr(1'b1, 7'h01, 24'h000010, 24'd0);
    send_hdr(1'b0, 7'h01, 24'h000010, 24'd0);
    idle(8);
    chk("R6", "no requests", 32'(nlog - b), 32'd0);
    chk("R6", "no output", 32'(nrx - r), 32'd0);
    send_hdr(1'b0, 7'h01, 24'h000007, 24'd1);
    wait_rx(r + 2);
    chk("R6", "next packet hi", 32'(rx[r]), 32'(model(24'h7) >> 8));
    chk("R6", "next packet lo", 32'(rx[r+1]), 32'(model(24'h7) & 16'hFF));
  endtask

  task automatic t_read_single;
    int b = nlog;
    int r = nrx;
    send_hdr(1'b0, 7'h01, 24'h234567, 24'd1);
    wait_rx(r + 2);
    idle(3);
    chk("R7", "byte count", 32'(nrx - r), 32'd2);
    chk("R7", "hi byte", 32'(rx[r]), 32'(model(24'h234567) >> 8));
    chk("R7", "lo byte", 32'(rx[r+1]), 32'(model(24'h234567) & 16'hFF));
    chk("R7", "read we", 32'(lg_we[b]), 32'd0);
    chk("R3", "read addr", 32'(lg_addr[b]), 32'h234567);
  endtask

  task automatic t_read_burst_stall;
    int b = nlog;
    int r = nrx;
    stall_en = 1'b1;
    send_hdr(1'b0, 7'h01, 24'h000100, 24'd4);
    wait_rx(r + 8);
    idle(6);
    stall_en = 1'b0;
    chk("R7", "burst bytes", 32'(nrx - r), 32'd8);
    chk("R7", "burst requests", 32'(nlog - b), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R9", "stalled hi", 32'(rx[r+2*i]), 32'(model(24'(256+i)) >> 8));
      chk("R9", "stalled lo", 32'(rx[r+2*i+1]), 32'(model(24'(256+i)) & 16'hFF));
      chk("R5", "read addr step", 32'(lg_addr[b+i]), 32'(256+i));
    end
    chk("R9", "input/output overlap", 32'(overlap), 32'd0);
  endtask

  task automatic t_unknown;
    int b = nlog;
    int r = nrx;
    send_hdr(1'b1, 7'h05, 24'h000020, 24'd2);
    send_word(16'hAAAA); send_word(16'h5555);
    send_hdr(1'b0, 7'h05, 24'h000020, 24'd2);
    wait_rx(r + 4);
    idle(3);
    chk("R8", "no requests", 32'(nlog - b), 32'd0);
    chk("R8", "byte count", 32'(nrx - r), 32'd4);
    for (int i = 0; i < 4; i++)
      chk("R8", "zero byte", 32'(rx[r+i]), 32'd0);
  endtask

  task automatic t_stray;
    int r = nrx;
    stray = 1'b1; @(negedge clk); stray = 1'b0;
    idle(3);
    chk("R10", "no output from stray", 32'(nrx - r), 32'd0);
    send_hdr(1'b0, 7'h01, 24'h000009, 24'd1);
    wait_rx(r + 2);
    idle(3);
    chk("R10", "byte count", 32'(nrx - r), 32'd2);
    chk("R10", "hi", 32'(rx[r]), 32'(model(24'h9) >> 8));
    chk("R10", "lo", 32'(rx[r+1]), 32'(model(24'h9) & 16'hFF));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; stall_en = 1'b0; stray = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_single_write();
    t_burst_write();
    t_resync();
    t_zero_len();
    t_read_single();
    t_read_burst_stall();
    t_unknown();
    t_stray();
    chk("R11", "back-to-back requests", 32'(dbl_req), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
      $finish;
    end
  end
endmodule